// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the host-visible control state for a bus-master storage DMA engine with several channels. A host reaches it through a byte-addressed I/O port with byte, halfword and word accesses. Each channel owns an 8-byte window: a command byte, a status byte, two reserved byte slots, and a 32-bit pointer to the descriptor table. Channel windows are packed back to back, so the default two channels fill a 16-byte region.

The block does not move data. It tells the data mover when to begin and when to abandon a transfer, using one-cycle pulses. It gives the data mover a working descriptor pointer that is reloaded on every host address write and that the mover can step forward. The mover reports back through per-channel inputs that end the active state and raise the error and interrupt flags.

Write data and read data are right-aligned: a byte access uses bits 7:0, a halfword access uses bits 15:0. The access size is encoded 0 = byte, 1 = halfword, 2 or 3 = word. A write to channel offsets 0 to 3 takes only data bits 7:0, whatever the size.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command, status, address and working pointer of every channel read zero, and no start or cancel pulse is driven.
- R2: A write to channel offset 0 stores only data bits 0 (start) and 3 (direction), so offset 0 reads back the written byte AND 0x09. The direction output follows bit 3.
- R3: A command write with bit 0 clear drives that channel's cancel pulse high for exactly the one cycle after the write.
- R4: A command write with bit 0 set while status bit 0 (active) is clear sets the active bit and drives one start pulse in the cycle after the write. If the active bit is already set, no start pulse is driven.
- R5: A write to offset 2 loads status bits 6 and 5 from the data and leaves bit 0 unchanged. It clears status bit 1 and status bit 2 only where the data holds a one. Status bits 7, 4 and 3 always read zero.
- R6: The error-set input sets status bit 1, the interrupt-set input sets status bit 2, and the active-clear input clears status bit 0. A set input wins over a host write-one-to-clear of the same bit in the same cycle.
- R7: Writes to offsets 4 to 7 update the descriptor address. A byte or halfword write is placed at a left shift of 8 times offset bits 1:0, and bits shifted past bit 31 are dropped. A word write replaces the whole register. Address bits 1:0 always hold zero.
- R8: A read at offsets 4 to 7 returns the stored address shifted right by 8 times offset bits 1:0, masked to 8 bits for a byte read or 16 bits for a halfword read. A word read returns the whole address.
- R9: Every address write, of any width, copies the new address into the channel's working pointer output. A pointer-advance input adds 8 to the working pointer and leaves the address register unchanged.
- R10: Channel n occupies offsets 8n to 8n+7. An access to one channel never changes another channel's state.
- R11: Offsets 1 and 3 of every channel always read 0xFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_wr | input | 1 | Write strobe for one cycle |
| io_off | input | 4 | Byte offset into the channel region |
| io_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| io_wdata | input | 32 | Right-aligned write data |
| io_rdata | output | 32 | Right-aligned read data, combinational from io_off and io_size |
| act_clr | input | 2 | Per channel: clear the active status bit |
| err_set | input | 2 | Per channel: set the error status bit |
| irq_set | input | 2 | Per channel: set the interrupt status bit |
| ptr_adv | input | 2 | Per channel: advance the working pointer by one descriptor |
| start_pulse | output | 2 | Per channel: begin a transfer |
| cancel_pulse | output | 2 | Per channel: abandon any transfer |
| dir | output | 2 | Per channel: transfer direction from command bit 3 |
| desc_ptr | output | 64 | Per channel: working descriptor pointer, channel n at bits 32n+31:32n |

## Verification
A wrong status next-state shows up at the very next read of offset 2, or as a missing or extra start pulse one cycle after a command write. The bench sweeps every command byte and every status byte through the port and compares them with an arithmetic model. A lane error in the address merge shows up one cycle after the write, both in the word read-back and on the working pointer output. The bench sweeps every offset and size on both channels and reads back every sub-field, so a wrong shift, mask or alignment is caught on the first write that touches it.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned WIN_B   = 8;     // bytes per channel window

  // access size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // status bit positions
  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_IRQ = 2;

  localparam logic [7:0] CMD_KEEP = 8'h09;
  localparam logic [7:0] RSV_FILL = 8'hFF;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    if (sz == SZ_BYTE)      m = 32'h0000_00FF;
    else if (sz == SZ_HALF) m = 32'h0000_FFFF;
    else                    m = 32'hFFFF_FFFF;
    return m;
  endfunction
endpackage

// File: rtl/bmdma_ctl.sv
module bmdma_ctl
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       st_we,
  input  logic [7:0] wbyte,
  input  logic       act_clr,
  input  logic       err_set,
  input  logic       irq_set,
  output logic [7:0] cmd_q,
  output logic [7:0] st_q,
  output logic       start_q,
  output logic       cancel_q
);
  logic       start_req;
  logic       cancel_req;
  logic [7:0] cmd_nxt;
  logic [7:0] st_nxt;
  logic       st_en;

  always_comb begin
    start_req  = cmd_we && wbyte[0] && !st_q[ST_ACT];
    cancel_req = cmd_we && !wbyte[0];
    cmd_nxt    = wbyte & CMD_KEEP;
    st_en      = st_we || act_clr || err_set || irq_set || start_req;

    st_nxt = st_q;
    if (st_we) begin
      st_nxt[7]   = 1'b0;
      st_nxt[6:5] = wbyte[6:5];
      st_nxt[4:3] = 2'b00;
      st_nxt[ST_IRQ:ST_ERR] = st_q[ST_IRQ:ST_ERR] & ~wbyte[ST_IRQ:ST_ERR];
    end
    if (act_clr)   st_nxt[ST_ACT] = 1'b0;
    if (start_req) st_nxt[ST_ACT] = 1'b1;
    if (err_set)   st_nxt[ST_ERR] = 1'b1;
    if (irq_set)   st_nxt[ST_IRQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      st_q     <= '0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= cmd_nxt;
      if (st_en)  st_q  <= st_nxt;
      start_q  <= start_req;
      cancel_q <= cancel_req;
    end
  end

  AST_CMD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~CMD_KEEP) == 8'h00); // R2
  AST_START_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> st_q[ST_ACT]); // R4
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !$past(st_q[ST_ACT])); // R4
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> st_q[ST_ERR]); // R6
  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> st_q[ST_IRQ]); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[7] == 1'b0) && (st_q[4:3] == 2'b00)); // R5
endmodule

// File: rtl/bmdma_addr.sv
module bmdma_addr
  import bmdma_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    sz,
  input  logic [1:0]    lane,
  input  logic [DW-1:0] wdata,
  input  logic          adv,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] ptr_q,
  output logic [DW-1:0] rd_data
);
  localparam logic [DW-1:0] ALIGN_M = ~(DW'(3));

  logic [DW-1:0] fmask;
  logic [DW-1:0] lmask;
  logic [DW-1:0] ins;
  logic [DW-1:0] addr_nxt;
  logic [DW-1:0] ptr_nxt;
  logic          ptr_en;
  logic [4:0]    shamt;
  logic          is_word;

  always_comb begin
    is_word  = sz[1];
    fmask    = size_mask(sz);
    shamt    = is_word ? 5'd0 : {lane, 3'b000};
    lmask    = fmask << shamt;
    ins      = (wdata & fmask) << shamt;
    addr_nxt = ((addr_q & ~lmask) | ins) & ALIGN_M;
    rd_data  = is_word ? addr_q : ((addr_q >> shamt) & fmask);
    ptr_en   = wr_en || adv;
    ptr_nxt  = wr_en ? addr_nxt : (ptr_q + DW'(STEP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (wr_en)  addr_q <= addr_nxt;
      if (ptr_en) ptr_q  <= ptr_nxt;
    end
  end

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[1:0] == 2'b00); // R7
  AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr_q == addr_q)); // R9
  AST_ADV_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en) |=> $stable(addr_q)); // R9
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    off,
  input  logic [1:0]    sz,
  input  logic [DW-1:0] wdata,
  input  logic          act_clr,
  input  logic          err_set,
  input  logic          irq_set,
  input  logic          adv,
  output logic [DW-1:0] rd_data,
  output logic          start_o,
  output logic          cancel_o,
  output logic          dir_o,
  output logic [DW-1:0] ptr_o
);
  logic          cmd_we;
  logic          st_we;
  logic          addr_we;
  logic [7:0]    cmd_q;
  logic [7:0]    st_q;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] addr_rd;

  always_comb begin
    cmd_we  = wr_en && (off == 3'd0);
    st_we   = wr_en && (off == 3'd2);
    addr_we = wr_en && off[2];
  end

  bmdma_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .st_we    (st_we),
    .wbyte    (wdata[7:0]),
    .act_clr  (act_clr),
    .err_set  (err_set),
    .irq_set  (irq_set),
    .cmd_q    (cmd_q),
    .st_q     (st_q),
    .start_q  (start_o),
    .cancel_q (cancel_o)
  );

  bmdma_addr #(.DW(DW), .STEP(STEP)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_we),
    .sz      (sz),
    .lane    (off[1:0]),
    .wdata   (wdata),
    .adv     (adv),
    .addr_q  (addr_q),
    .ptr_q   (ptr_o),
    .rd_data (addr_rd)
  );

  always_comb begin
    dir_o = cmd_q[3];
    unique case (off)
      3'd0:    rd_data = DW'(cmd_q);
      3'd2:    rd_data = DW'(st_q);
      3'd1,
      3'd3:    rd_data = DW'(RSV_FILL);
      default: rd_data = addr_rd;
    endcase
  end

  AST_DIR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (dir_o == $past(wdata[3]))); // R2
  AST_CANCEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !wdata[0]) |=> cancel_o); // R3
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && cancel_o)); // R3
  AST_NO_ADDR_DRIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(addr_q)); // R10
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned STEP = 8,
  localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned OFFW = CHW + $clog2(WIN_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [OFFW-1:0]   io_off,
  input  logic [1:0]        io_size,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic [NCH-1:0]    act_clr,
  input  logic [NCH-1:0]    err_set,
  input  logic [NCH-1:0]    irq_set,
  input  logic [NCH-1:0]    ptr_adv,
  output logic [NCH-1:0]    start_pulse,
  output logic [NCH-1:0]    cancel_pulse,
  output logic [NCH-1:0]    dir,
  output logic [NCH*DW-1:0] desc_ptr
);
  logic [CHW-1:0] sel;
  logic [DW-1:0]  ch_rd [NCH];

  assign sel = io_off[OFFW-1:OFFW-CHW];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_wr;
    assign ch_wr = io_wr && (sel == CHW'(g));

    bmdma_chan #(.DW(DW), .STEP(STEP)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ch_wr),
      .off      (io_off[2:0]),
      .sz       (io_size),
      .wdata    (io_wdata),
      .act_clr  (act_clr[g]),
      .err_set  (err_set[g]),
      .irq_set  (irq_set[g]),
      .adv      (ptr_adv[g]),
      .rd_data  (ch_rd[g]),
      .start_o  (start_pulse[g]),
      .cancel_o (cancel_pulse[g]),
      .dir_o    (dir[g]),
      .ptr_o    (desc_ptr[g*DW +: DW])
    );
  end

  always_comb begin
    io_rdata = '1;
    for (int i = 0; i < NCH; i++) begin
      if (sel == CHW'(i)) io_rdata = ch_rd[i];
    end
  end

  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> (start_pulse == '0) && (cancel_pulse == '0)); // R10
endmodule

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [3:0]  io_off;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic [1:0]  act_clr, err_set, irq_set, ptr_adv;
  logic [1:0]  start_pulse, cancel_pulse, dir;
  logic [63:0] desc_ptr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  bmdma_regs i_bmdma_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_off(io_off),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .act_clr(act_clr), .err_set(err_set), .irq_set(irq_set),
    .ptr_adv(ptr_adv), .start_pulse(start_pulse),
    .cancel_pulse(cancel_pulse), .dir(dir), .desc_ptr(desc_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_off = off; io_size = sz; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] off, input logic [1:0] sz, output logic [31:0] d);
    io_off = off; io_size = sz;
    #1;
    d = io_rdata;
  endtask

  task automatic pulse(input int ch, input bit a, input bit e, input bit q, input bit p);
    @(negedge clk);
    act_clr[ch] = a; err_set[ch] = e; irq_set[ch] = q; ptr_adv[ch] = p;
    @(negedge clk);
    act_clr = '0; err_set = '0; irq_set = '0; ptr_adv = '0;
  endtask

  function automatic logic [31:0] m_wr(input logic [31:0] old, input int off,
                                       input int sz, input logic [31:0] v);
    logic [31:0] m;
    int sh;
    if (sz >= 2) return v & ~32'h3;
    sh = (off % 4) * 8;
    m = (sz == 0) ? 32'hFF : 32'hFFFF;
    return ((old & ~(m << sh)) | ((v & m) << sh)) & ~32'h3;
  endfunction

  function automatic logic [31:0] m_rd(input logic [31:0] a, input int off, input int sz);
    logic [31:0] m;
    if (sz >= 2) return a;
    m = (sz == 0) ? 32'hFF : 32'hFFFF;
    return (a >> ((off % 4) * 8)) & m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] am [2];
    logic [7:0]  st;
    bit act;
    io_wr = 0; io_off = 0; io_size = 0; io_wdata = 0;
    act_clr = 0; err_set = 0; irq_set = 0; ptr_adv = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      do_rd(4'(c*8+0), 0, r); chk("R1 cmd", r, 0);
      do_rd(4'(c*8+2), 0, r); chk("R1 status", r, 0);
      do_rd(4'(c*8+4), 2, r); chk("R1 addr", r, 0);
    end
    chk("R1 ptr", desc_ptr[31:0] | desc_ptr[63:32], 0);
    chk("R1 pulses", {30'd0, start_pulse | cancel_pulse}, 0);

    // R2 R3 R4 command sweep on channel 0
    act = 0;
    for (int v = 0; v < 256; v++) begin
      do_wr(0, 0, 32'(v));
      chk("R4 start", {31'd0, start_pulse[0]}, {31'd0, (v % 2 == 1) && !act});
      chk("R3 cancel", {31'd0, cancel_pulse[0]}, {31'd0, v % 2 == 0});
      if (v % 2 == 1) act = 1;
      do_rd(0, 0, r); chk("R2 cmd", r, 32'(v) & 32'h9);
      chk("R2 dir", {31'd0, dir[0]}, {31'd0, v[3]});
      do_rd(2, 0, r); chk("R4 active", r, {31'd0, act});
      if (v % 8 == 7) begin
        pulse(0, 1, 0, 0, 0); act = 0;
        do_rd(2, 0, r); chk("R6 act clear", r, 0);
      end
    end
    @(negedge clk);
    chk("R3 single cycle", {30'd0, cancel_pulse | start_pulse}, 0);

    // R5 status sweep on channel 1
    do_wr(8, 0, 1);
    st = 8'h01;
    for (int v = 0; v < 256; v++) begin
      pulse(1, 0, 1, 1, 0);
      st = st | 8'h06;
      do_wr(10, 0, 32'(v));
      st = (8'(v) & 8'h60) | (st & 8'h01) | (st & ~8'(v) & 8'h06);
      do_rd(10, 0, r); chk("R5 status", r, {24'd0, st});
    end
    do_rd(2, 0, r); chk("R10 ch0 status untouched", r, 0);

    // R6 set beats write-one-to-clear in the same cycle
    pulse(1, 0, 1, 1, 0);
    @(negedge clk);
    io_wr = 1; io_off = 10; io_size = 0; io_wdata = 32'h06; err_set[1] = 1;
    @(negedge clk);
    io_wr = 0; err_set = 0;
    do_rd(10, 0, r); chk("R6 set wins", r, 32'h03);
    pulse(1, 1, 0, 0, 0);
    do_rd(10, 0, r); chk("R6 act clear", r, 32'h02);

    // R7 R8 R9 address sweep
    am[0] = 0; am[1] = 0;
    for (int c = 0; c < 2; c++) begin
      for (int o = 4; o < 8; o++) begin
        for (int s = 0; s < 3; s++) begin
          for (int p = 0; p < 4; p++) begin
            logic [31:0] d;
            d = (32'hA5C3_96F1 << p) ^ 32'(o * 977 + s * 131 + c * 7 + p);
            do_wr(4'(c*8+o), 2'(s), d);
            am[c] = m_wr(am[c], o, s, d);
            do_rd(4'(c*8+4), 2, r); chk("R7 addr word", r, am[c]);
            chk("R9 ptr reload", desc_ptr[c*32 +: 32], am[c]);
            for (int ro = 4; ro < 8; ro++)
              for (int rs = 0; rs < 2; rs++) begin
                do_rd(4'(c*8+ro), 2'(rs), r); chk("R8 sub read", r, m_rd(am[c], ro, rs));
              end
          end
        end
      end
      do_rd(4'((1-c)*8+4), 2, r); chk("R10 other addr", r, am[1-c]);
    end

    // R9 pointer advance
    for (int k = 1; k <= 3; k++) begin
      pulse(0, 0, 0, 0, 1);
      chk("R9 advance", desc_ptr[31:0], am[0] + 32'(8 * k));
    end
    do_rd(4, 2, r); chk("R9 addr kept", r, am[0]);
    do_wr(5, 0, 32'h12);
    am[0] = m_wr(am[0], 5, 0, 32'h12);
    chk("R9 reload after advance", desc_ptr[31:0], am[0]);

    // R11 reserved slots
    for (int c = 0; c < 2; c++) begin
      do_wr(4'(c*8+1), 0, 0);
      do_wr(4'(c*8+3), 2, 0);
      do_rd(4'(c*8+1), 0, r); chk("R11 off1", r, 32'hFF);
      do_rd(4'(c*8+3), 0, r); chk("R11 off3", r, 32'hFF);
      do_rd(4'(c*8+4), 2, r); chk("R11 addr untouched", r, am[c]);
    end
    do_rd(0, 0, r); chk("R11 cmd untouched", r, 32'h9 & 32'hFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule